// File: doc/BRIEF.md
# WFI Clock-Gating Wake Controller

This block decides when the clock of a core and its L2 cluster may be stopped while the core waits for an interrupt. It also decides when that clock must come back. The core reports that it has halted. If the power sequencer is idle at that moment, the controller raises a registered gate request. An integrated clock-gate cell outside the block consumes a final clock enable, which the controller also produces.

Two kinds of event restore the clock. The first is any interrupt source. Eight raw interrupt lines are first passed through a multi-flop synchronizer inside the block. The second is a pending flit on any of three incoming interconnect channels: snoop, response or data. A pending snoop flit also forces the clock enable high in the same cycle, without waiting for the state machine. A separate power-down gate input can hold the clock off on its own. A parameter disables WFI gating entirely.

Top module: `wfi_clk_gate_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the controller returns to the run state. After that edge `gate_req` is 0 and every synchronizer flop is 0.
- R2: In the run state, when `core_halted` and `lp_idle` are both sampled high at an edge, the controller enters the gated state at that edge and `gate_req` becomes 1 after it.
- R3: `gate_req` is 1 exactly while the controller is in the gated state.
- R4: Each bit of `irq_src` passes through `SYNC_STAGES` (default 3) flops. In the gated state, a nonzero synchronized vector moves the controller to the interrupt-wake state and clears `gate_req`. This happens at the rising edge that follows the one where the synchronizer output became nonzero: the `SYNC_STAGES`+1-th edge after the raw bit is first sampled high. A one-cycle raw pulse is enough. Bit order, high to low, is: machine software, machine timer, machine external, supervisor external, non-maskable A, non-maskable B, debug, message-info valid. All eight bits have equal effect.
- R5: In the gated state with no synchronized interrupt, any of `flit_pend_snoop`, `flit_pend_resp` or `flit_pend_data` sampled high moves the controller to the flit-wake state and clears `gate_req` at that edge.
- R6: In either wake state, `gate_req` stays 0 while `core_halted` stays high, whatever `lp_idle` does. The controller goes back to the run state at the first edge where `core_halted` is sampled low. So gating resumes only after `core_halted` has been low for at least one cycle.
- R7: `clk_en` is combinationally `(!gate_req && !pdn_gate) || flit_pend_snoop`. A snoop flag raises it within the same cycle, even in the gated state or under `pdn_gate`.
- R8: With `GATE_EN` = 0, `gate_req` is held at 0 under all inputs.
- R9: While `lp_idle` is low, a halted core never enters the gated state. Interrupts and flits arriving in the run state have no effect on `gate_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock (free running, before the gate cell) |
| rst_n | input | 1 | Synchronous active-low reset |
| core_halted | input | 1 | Synchronized flag: core halted in wait-for-interrupt |
| lp_idle | input | 1 | Power sequencer is idle, so gating is allowed |
| pdn_gate | input | 1 | Power-down clock gate request from the power sequencer |
| flit_pend_snoop | input | 1 | Snoop channel has a flit pending |
| flit_pend_resp | input | 1 | Response channel has a flit pending |
| flit_pend_data | input | 1 | Data channel has a flit pending |
| irq_src | input | 8 | Raw interrupt sources, order as in R4 |
| gate_req | output | 1 | Registered WFI gate request |
| clk_en | output | 1 | Final enable for the clock-gate cell |

## Verification
Two functions of the block can land on the same cycle. One is the combinational snoop override of `clk_en`. The other is the state machine leaving the gated state on a flit. A snoop pulse raised during the gated state provokes both at once: for that cycle `clk_en` must be high while `gate_req` is still 1, and from the next edge `gate_req` must be 0. The same overlap is provoked with an interrupt whose synchronized output arrives in the cycle a snoop flag is raised, and with `pdn_gate` high alongside the snoop flag. A behavioural reference model, fed the same inputs, judges every cycle for both the gating and the gating-disabled build.

// File: rtl/wfi_cg_pkg.sv
// Shared definitions for the WFI clock-gating wake controller.
// Assumes: consumers import this package before declaring state registers.
package wfi_cg_pkg;

    // Controller states; RUN must be the reset encoding.
    typedef enum logic [1:0] {
        WS_RUN       = 2'd0,
        WS_GATED     = 2'd1,
        WS_IRQ_WAKE  = 2'd2,
        WS_FLIT_WAKE = 2'd3
    } wake_state_e;

    // Number of interrupt sources packed into the wake vector.
    localparam int unsigned IRQ_SRC_N = 8;

    // Number of interconnect channels that can report a pending flit.
    localparam int unsigned FLIT_CHAN_N = 3;

endpackage

// File: rtl/wfi_irq_sync.sv
// Multi-flop synchronizer for a vector of interrupt sources.
// What it does: delays each bit through STAGES flops, clearing all on reset.
// Assumes: STAGES >= 2; each bit is an independent level, no bus coherency needed.
module wfi_irq_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop samples the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[s] <= '0;
                else        pipe_q[s] <= din;
            end
        end else begin : g_rest
            // Later flops resolve metastability of the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[s] <= '0;
                else        pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign dout = pipe_q[LAST];

    // R1
    sync_reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dout == '0));

endmodule

// File: rtl/wfi_flit_merge.sv
// Merges the per-channel flit-pending flags into one wake flag.
// What it does: reduction OR over the channel vector.
// Assumes: flags are already in the cluster clock domain.
module wfi_flit_merge #(
    parameter int unsigned CHAN_N = 3
) (
    input  logic [CHAN_N-1:0] chan_pend,
    output logic              any_pend
);
    // Any channel with a pending flit is a wake reason.
    always_comb begin
        any_pend = 1'b0;
        for (int c = 0; c < CHAN_N; c++) begin
            any_pend = any_pend | chan_pend[c];
        end
    end
endmodule

// File: rtl/wfi_wake_fsm.sv
// State machine deciding whether the cluster clock may be gated.
// What it does: enters GATED from RUN when the core is halted and the power
//   sequencer is idle; leaves on an interrupt or a pending flit; returns to
//   RUN only once the halted flag drops.
// Assumes: halted, idle and the interrupt vector are synchronous to clk.
module wfi_wake_fsm
    import wfi_cg_pkg::*;
#(
    parameter bit          GATE_EN = 1'b1,
    parameter int unsigned IRQ_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halted,
    input  logic             lp_idle,
    input  logic [IRQ_W-1:0] irq_sync,
    input  logic             flit_any,
    output logic             gate_q
);
    wake_state_e st_q, st_nxt;
    logic        irq_any;

    // Any synchronized source counts as an interrupt wake.
    assign irq_any = |irq_sync;

    // Next-state decision; interrupts are checked before flits.
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            WS_RUN: begin
                if (halted && lp_idle) st_nxt = WS_GATED;
            end
            WS_GATED: begin
                if (irq_any)       st_nxt = WS_IRQ_WAKE;
                else if (flit_any) st_nxt = WS_FLIT_WAKE;
            end
            WS_IRQ_WAKE, WS_FLIT_WAKE: begin
                if (!halted) st_nxt = WS_RUN;
            end
            default: st_nxt = WS_RUN;
        endcase
    end

    // State and gate-request registers; the request follows the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WS_RUN;
            gate_q <= 1'b0;
        end else begin
            st_q   <= st_nxt;
            gate_q <= GATE_EN && (st_nxt == WS_GATED);
        end
    end

    // R1
    reset_to_run_chk: assert property (@(posedge clk)
        !rst_n |=> (st_q == WS_RUN && !gate_q));

    // R2
    enter_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WS_RUN && halted && lp_idle) |=> (st_q == WS_GATED && gate_q == GATE_EN));

    // R3
    gate_only_in_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> (st_q == WS_GATED));

    // R4
    irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WS_GATED && irq_sync != '0) |=> (st_q == WS_IRQ_WAKE && !gate_q));

    // R5
    flit_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WS_GATED && irq_sync == '0 && flit_any) |=> (st_q == WS_FLIT_WAKE && !gate_q));

    // R6
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == WS_IRQ_WAKE || st_q == WS_FLIT_WAKE) && halted) |=> !gate_q);

    // R9
    idle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WS_RUN && !lp_idle) |=> !gate_q);

    if (!GATE_EN) begin : g_off_chk
        // R8
        gate_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !gate_q);
    end

endmodule

// File: rtl/wfi_clk_en.sv
// Final clock-enable combination for the clock-gate cell.
// What it does: enable unless WFI or power-down gating is requested; a
//   pending snoop flit overrides both in the same cycle.
// Assumes: the downstream gate cell latches the enable itself.
module wfi_clk_en (
    input  logic clk,
    input  logic rst_n,
    input  logic wfi_gate,
    input  logic pdn_gate,
    input  logic snoop_pend,
    output logic clk_en
);
    // Combine the gating requests with the snoop override.
    always_comb begin
        clk_en = (!wfi_gate && !pdn_gate) || snoop_pend;
    end

    // R7
    snoop_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_pend |-> clk_en);

    // R7
    gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wfi_gate && !snoop_pend) |-> !clk_en);

endmodule

// File: rtl/wfi_clk_gate_ctrl.sv
// Top of the WFI clock-gating wake controller.
// What it does: synchronizes interrupt sources, merges flit-pending flags,
//   runs the gating state machine and forms the clock-gate enable.
// Assumes: core_halted, lp_idle and the flit flags are already synchronous
//   to clk; irq_src bits are raw and asynchronous.
module wfi_clk_gate_ctrl
    import wfi_cg_pkg::*;
#(
    parameter bit          GATE_EN     = 1'b1,
    parameter int unsigned SYNC_STAGES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 core_halted,
    input  logic                 lp_idle,
    input  logic                 pdn_gate,
    input  logic                 flit_pend_snoop,
    input  logic                 flit_pend_resp,
    input  logic                 flit_pend_data,
    input  logic [IRQ_SRC_N-1:0] irq_src,
    output logic                 gate_req,
    output logic                 clk_en
);
    logic [IRQ_SRC_N-1:0]   irq_sync;
    logic [FLIT_CHAN_N-1:0] chan_pend;
    logic                   flit_any;

    // Channel order in the merged vector: data, response, snoop.
    assign chan_pend = {flit_pend_data, flit_pend_resp, flit_pend_snoop};

    wfi_irq_sync #(
        .WIDTH  (IRQ_SRC_N),
        .STAGES (SYNC_STAGES)
    ) u_irq_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_src),
        .dout  (irq_sync)
    );

    wfi_flit_merge #(
        .CHAN_N (FLIT_CHAN_N)
    ) u_flit_merge (
        .chan_pend (chan_pend),
        .any_pend  (flit_any)
    );

    wfi_wake_fsm #(
        .GATE_EN (GATE_EN),
        .IRQ_W   (IRQ_SRC_N)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .halted   (core_halted),
        .lp_idle  (lp_idle),
        .irq_sync (irq_sync),
        .flit_any (flit_any),
        .gate_q   (gate_req)
    );

    wfi_clk_en u_clk_en (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfi_gate   (gate_req),
        .pdn_gate   (pdn_gate),
        .snoop_pend (flit_pend_snoop),
        .clk_en     (clk_en)
    );

    // R5
    any_flit_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_req && irq_sync == '0 && (flit_pend_resp || flit_pend_data)) |=> !gate_req);

endmodule

// File: tb/tb_wfi_clk_gate_ctrl.sv
module tb_wfi_clk_gate_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_halted = 1'b0;
    logic       lp_idle = 1'b0;
    logic       pdn_gate = 1'b0;
    logic       snp = 1'b0;
    logic       rsp = 1'b0;
    logic       dat = 1'b0;
    logic [7:0] irq = 8'h00;
    logic       gate_req, clk_en, gate_req_ng, clk_en_ng;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;  // 125 MHz

    wfi_clk_gate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .core_halted(core_halted), .lp_idle(lp_idle),
        .pdn_gate(pdn_gate), .flit_pend_snoop(snp), .flit_pend_resp(rsp),
        .flit_pend_data(dat), .irq_src(irq), .gate_req(gate_req), .clk_en(clk_en));

    wfi_clk_gate_ctrl #(.GATE_EN(1'b0)) dut_ng (
        .clk(clk), .rst_n(rst_n), .core_halted(core_halted), .lp_idle(lp_idle),
        .pdn_gate(pdn_gate), .flit_pend_snoop(snp), .flit_pend_resp(rsp),
        .flit_pend_data(dat), .irq_src(irq), .gate_req(gate_req_ng), .clk_en(clk_en_ng));

    // Reference model: 0 run, 1 gated, 2 irq wake, 3 flit wake.
    int         m_state = 0;
    bit         m_gate = 1'b0;
    logic [7:0] m_pipe[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0;
            m_gate  = 1'b0;
            m_pipe  = '{8'h00, 8'h00, 8'h00};
        end else begin
            logic [7:0] seen;
            seen = m_pipe.pop_front();
            m_pipe.push_back(irq);
            case (m_state)
                0: if (core_halted && lp_idle) m_state = 1;
                1: if (seen != 0) m_state = 2;
                   else if (snp || rsp || dat) m_state = 3;
                default: if (!core_halted) m_state = 0;
            endcase
            m_gate = (m_state == 1);
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // Compare both builds against the model on every clock, mid high phase.
    always @(posedge clk) begin
        #2;
        cyc++;
        check(cur_req, "gate_req", gate_req, m_gate);
        check(cur_req, "clk_en", clk_en, (!m_gate && !pdn_gate) || snp);
        // R8: gating-disabled build never requests a gate
        check("R8", "gate_req(off)", gate_req_ng, 1'b0);
        check("R8", "clk_en(off)", clk_en_ng, !pdn_gate || snp);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Take the gated state from run: core halts with the sequencer idle.
    task automatic go_gated();
        lp_idle = 1'b1;
        core_halted = 1'b1;
        step(2);
    endtask

    // Leave a wake state: drop halted for one cycle.
    task automatic release_halt();
        core_halted = 1'b0;
        step(1);
    endtask

    initial begin
        step(3);
        // R1: reset state explicitly
        check("R1", "reset gate_req", gate_req, 1'b0);
        check("R1", "reset clk_en", clk_en, 1'b1);
        rst_n = 1'b1;
        step(2);

        cur_req = "R2";
        go_gated();
        check("R2", "gated after halt+idle", gate_req, 1'b1);

        cur_req = "R7";
        snp = 1'b1;
        #1 check("R7", "snoop forces clk_en same cycle", clk_en, 1'b1);
        step(1);
        snp = 1'b0;
        cur_req = "R6";
        step(4);
        check("R6", "no regate while halted", gate_req, 1'b0);
        release_halt();
        core_halted = 1'b1;
        step(2);
        check("R6", "regate after halt low", gate_req, 1'b1);

        cur_req = "R5";
        rsp = 1'b1; step(1); rsp = 1'b0; step(1);
        check("R5", "resp wake", gate_req, 1'b0);
        release_halt(); go_gated();
        dat = 1'b1; step(1); dat = 1'b0; step(1);
        check("R5", "data wake", gate_req, 1'b0);
        release_halt(); go_gated();

        cur_req = "R4";
        for (int b = 0; b < 8; b++) begin
            irq = 8'h01 << b; step(1); irq = 8'h00;
            step(2);
            check("R4", "still gated during sync", gate_req, 1'b1);
            step(2);
            check("R4", "irq wake", gate_req, 1'b0);
            release_halt(); go_gated();
        end
        // R4/R7 overlap: synchronized irq and snoop land on the same cycle
        irq = 8'h80; step(1); irq = 8'h00; step(2);
        snp = 1'b1; pdn_gate = 1'b1; step(1); snp = 1'b0; pdn_gate = 1'b0;
        step(1);

        cur_req = "R9";
        release_halt();
        lp_idle = 1'b0; core_halted = 1'b1;
        irq = 8'hFF; rsp = 1'b1; step(6);
        irq = 8'h00; rsp = 1'b0;
        check("R9", "no gate without idle", gate_req, 1'b0);
        pdn_gate = 1'b1; step(2);
        snp = 1'b1; step(2); snp = 1'b0; pdn_gate = 1'b0;
        lp_idle = 1'b1; step(2);
        cur_req = "R3";
        check("R3", "gate once idle", gate_req, 1'b1);
        step(5);

        cur_req = "R1";
        rst_n = 1'b0; step(2);
        check("R1", "reset clears gate", gate_req, 1'b0);
        rst_n = 1'b1; core_halted = 1'b0; step(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule